// File: doc/BRIEF.md
# Exception Cause and Vector Unit

This unit sits beside the control sequencer of a multicycle processor and turns two synchronous fault requests into a precise trap. The two requests are an unrecognised opcode and a signed arithmetic overflow. When either is raised it latches a cause code and the address of the instruction that faulted. It also moves the processor into supervisor mode with interrupts masked, and it issues a one-cycle redirect whose target is the handler entry. The sequencer uses that redirect as an extra source for the program counter.

The handler entry comes from one of two schemes, picked per trap by an input. One is a single shared entry. The other is a table indexed by cause, with room for 32 instructions per cause. A return-from-trap strobe restores the mode and interrupt-enable that were in force before the trap. It does this in the same edge that redirects fetch back to the saved address. A one-level stack inside the status state holds the earlier mode and enable.

Top module: `exc_vector_unit`

## Requirements
- R1: While rst is high, and on the first edge after it falls with no request, the outputs are kernel_o=1, ie_o=0, cause_o=0, epc_o=0, next_pc_o=0 and redirect_o=0. The stacked state resets to user mode (0) with interrupts enabled (1), so a return issued straight after reset enters user mode.
- R2: On the edge where a request is sampled, cause_o becomes 0 for an unrecognised opcode (undef_req_i) or 1 for overflow (ovf_req_i).
- R3: When undef_req_i and ovf_req_i are high in the same cycle, cause_o becomes 0.
- R4: On the trap edge, epc_o becomes pc_i minus 4, because pc_i already holds the incremented fetch address.
- R5: With vec_mode_i=0 on the trap cycle, next_pc_o becomes 0x80000080 and redirect_o is 1 for the following cycle.
- R6: With vec_mode_i=1 on the trap cycle, next_pc_o becomes 0x80 + (cause << 7): 0x80 for cause 0 and 0x100 for cause 1.
- R7: On the trap edge, kernel_o becomes 1 and ie_o becomes 0. The previous kernel_o/ie_o pair is pushed into the one-level stack, including when a trap is taken while already in supervisor mode.
- R8: When eret_i is high with no request, the next edge loads kernel_o/ie_o from the stack, sets next_pc_o to the current epc_o and pulses redirect_o. The stack itself is left unchanged.
- R9: When eret_i and a request are high in the same cycle, the trap is taken and the return is ignored.
- R10: rf_we_o is 0 in any cycle where a request is high, and follows rf_we_i otherwise (combinational).
- R11: redirect_o is 1 only for the one cycle after a trap or return edge. When neither happened, it is 0 and next_pc_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| undef_req_i | input | 1 | Unrecognised opcode fault request |
| ovf_req_i | input | 1 | Arithmetic overflow fault request |
| eret_i | input | 1 | Return-from-trap strobe |
| vec_mode_i | input | 1 | 0 = single entry, 1 = cause-indexed entry |
| pc_i | input | XLEN | Incremented program counter of the current instruction |
| rf_we_i | input | 1 | Register write request from the sequencer |
| rf_we_o | output | 1 | Register write after fault suppression |
| redirect_o | output | 1 | One-cycle program counter override |
| next_pc_o | output | XLEN | Override target (handler entry or return address) |
| cause_o | output | CODE_W | Latched cause code |
| epc_o | output | XLEN | Address of faulting instruction |
| kernel_o | output | 1 | Supervisor mode flag |
| ie_o | output | 1 | Interrupt enable flag |

## Verification
A trap and a return can arrive on the same edge, and both try to write the mode bits and next_pc_o. The bench provokes this by raising ovf_req_i together with eret_i while in supervisor mode. It judges the outcome on the next cycle: the handler address must be on next_pc_o, the saved address must be the new pc_i minus 4, and the mode must stay supervisor with interrupts off. A second collision, both fault requests in one cycle, is judged by the cause code and the cause-indexed entry it selects.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef struct packed {
    logic kernel;
    logic ie;
  } mode_t;

  localparam mode_t MODE_BOOT = '{kernel: 1'b1, ie: 1'b0};
  localparam mode_t MODE_STACK_RST = '{kernel: 1'b0, ie: 1'b1};
endpackage

// File: rtl/exc_prio.sv
module exc_prio #(
  parameter int NUM_SRC = 2,
  parameter int CODE_W  = 5
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               any,
  output logic [CODE_W-1:0]  code
);
  // lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    code = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) code = CODE_W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/exc_target.sv
module exc_target #(
  parameter int          XLEN       = 32,
  parameter int          CODE_W     = 5,
  parameter logic [31:0] FIXED_VEC  = 32'h8000_0080,
  parameter logic [31:0] VEC_BASE   = 32'h0000_0080,
  parameter int          SLOT_SHIFT = 7
) (
  input  logic              vec_mode,
  input  logic [CODE_W-1:0] code,
  output logic [XLEN-1:0]   target
);
  logic [XLEN-1:0] fixed_addr;
  logic [XLEN-1:0] table_addr;

  assign fixed_addr = XLEN'(FIXED_VEC);
  assign table_addr = XLEN'(VEC_BASE) + (XLEN'(code) << SLOT_SHIFT);
  assign target     = vec_mode ? table_addr : fixed_addr;
endmodule

// File: rtl/exc_status.sv
module exc_status
  import exc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  take,
  input  logic  ret,
  output mode_t cur,
  output mode_t prev
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= MODE_BOOT;
      prev <= MODE_STACK_RST;
    end else if (take) begin
      prev <= cur;
      cur  <= MODE_BOOT;
    end else if (ret) begin
      cur <= prev;
    end
  end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          CODE_W     = 5,
  parameter int          NUM_SRC    = 2,
  parameter logic [31:0] FIXED_VEC  = 32'h8000_0080,
  parameter logic [31:0] VEC_BASE   = 32'h0000_0080,
  parameter int          SLOT_SHIFT = 7,
  parameter int          INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              undef_req_i,
  input  logic              ovf_req_i,
  input  logic              eret_i,
  input  logic              vec_mode_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              rf_we_i,
  output logic              rf_we_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic [CODE_W-1:0] cause_o,
  output logic [XLEN-1:0]   epc_o,
  output logic              kernel_o,
  output logic              ie_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [NUM_SRC-1:0] req_vec;
  logic               take;
  logic               ret;
  logic [CODE_W-1:0]  code;
  logic [XLEN-1:0]    handler;
  mode_t              cur_mode;
  mode_t              prev_mode;

  // bit position equals cause code; lower code has priority
  always_comb begin
    req_vec    = '0;
    req_vec[0] = undef_req_i;
    req_vec[1] = ovf_req_i;
  end

  exc_prio #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_prio (
    .req  (req_vec),
    .any  (take),
    .code (code)
  );

  exc_target #(
    .XLEN(XLEN), .CODE_W(CODE_W), .FIXED_VEC(FIXED_VEC),
    .VEC_BASE(VEC_BASE), .SLOT_SHIFT(SLOT_SHIFT)
  ) u_target (
    .vec_mode (vec_mode_i),
    .code     (code),
    .target   (handler)
  );

  assign ret = eret_i & ~take;

  exc_status u_status (
    .clk  (clk),
    .rst  (rst),
    .take (take),
    .ret  (ret),
    .cur  (cur_mode),
    .prev (prev_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_o    <= '0;
      epc_o      <= '0;
      next_pc_o  <= '0;
      redirect_o <= 1'b0;
    end else if (take) begin
      cause_o    <= code;
      epc_o      <= pc_i - STEP;
      next_pc_o  <= handler;
      redirect_o <= 1'b1;
    end else if (ret) begin
      next_pc_o  <= epc_o;
      redirect_o <= 1'b1;
    end else begin
      redirect_o <= 1'b0;
    end
  end

  assign rf_we_o  = rf_we_i & ~take;
  assign kernel_o = cur_mode.kernel;
  assign ie_o     = cur_mode.ie;
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk #(
  parameter int          XLEN      = 32,
  parameter int          CODE_W    = 5,
  parameter logic [31:0] FIXED_VEC = 32'h8000_0080
) (
  input logic              clk,
  input logic              rst,
  input logic              undef_req_i,
  input logic              ovf_req_i,
  input logic              eret_i,
  input logic              vec_mode_i,
  input logic [XLEN-1:0]   pc_i,
  input logic              rf_we_o,
  input logic              redirect_o,
  input logic [XLEN-1:0]   next_pc_o,
  input logic [CODE_W-1:0] cause_o,
  input logic [XLEN-1:0]   epc_o,
  input logic              kernel_o,
  input logic              ie_o
);
  logic any_req;
  assign any_req = undef_req_i | ovf_req_i;

  p_undef_first_r3: assert property (@(posedge clk) disable iff (rst)
    undef_req_i |=> cause_o == '0);

  p_epc_r4: assert property (@(posedge clk) disable iff (rst)
    any_req |=> epc_o == $past(pc_i) - XLEN'(4));

  p_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    (any_req && !vec_mode_i) |=> (redirect_o && next_pc_o == XLEN'(FIXED_VEC)));

  p_entry_r7: assert property (@(posedge clk) disable iff (rst)
    any_req |=> (kernel_o && !ie_o));

  p_ret_r8: assert property (@(posedge clk) disable iff (rst)
    (eret_i && !any_req) |=> (redirect_o && next_pc_o == $past(epc_o)));

  p_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    any_req |-> !rf_we_o);

  p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (!any_req && !eret_i) |=> (!redirect_o && $stable(next_pc_o)));
endmodule

bind exc_vector_unit exc_vector_unit_chk #(
  .XLEN(XLEN), .CODE_W(CODE_W), .FIXED_VEC(FIXED_VEC)
) u_chk (
  .clk(clk), .rst(rst), .undef_req_i(undef_req_i), .ovf_req_i(ovf_req_i),
  .eret_i(eret_i), .vec_mode_i(vec_mode_i), .pc_i(pc_i), .rf_we_o(rf_we_o),
  .redirect_o(redirect_o), .next_pc_o(next_pc_o), .cause_o(cause_o),
  .epc_o(epc_o), .kernel_o(kernel_o), .ie_o(ie_o)
);

// File: tb/exc_vector_unit_bench.sv
module exc_vector_unit_bench;
  localparam int CLK_P = 10;
  localparam int XLEN  = 32;
  localparam int CW    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic undef_req, ovf_req, eret, vec_mode, rf_we_in;
  logic [XLEN-1:0] pc;
  logic rf_we_out, redirect, kernel, ie;
  logic [XLEN-1:0] next_pc, epc;
  logic [CW-1:0] cause;

  always #(CLK_P/2) clk = ~clk;

  exc_vector_unit u_exc_vector_unit (
    .clk(clk), .rst(rst), .undef_req_i(undef_req), .ovf_req_i(ovf_req),
    .eret_i(eret), .vec_mode_i(vec_mode), .pc_i(pc), .rf_we_i(rf_we_in),
    .rf_we_o(rf_we_out), .redirect_o(redirect), .next_pc_o(next_pc),
    .cause_o(cause), .epc_o(epc), .kernel_o(kernel), .ie_o(ie)
  );

  typedef struct {
    string           tag;
    logic            red;
    logic [XLEN-1:0] npc;
    logic [CW-1:0]   cause;
    logic [XLEN-1:0] epc;
    logic            k;
    logic            ie;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  logic            m_k = 1, m_ie = 0, m_pk = 0, m_pie = 1;
  logic [CW-1:0]   m_cause = 0;
  logic [XLEN-1:0] m_epc = 0, m_npc = 0;

  task automatic step(input string tag, input logic u, input logic o,
                      input logic r, input logic v, input logic [XLEN-1:0] p,
                      input logic we);
    exp_t e;
    @(negedge clk);
    undef_req = u; ovf_req = o; eret = r; vec_mode = v; pc = p; rf_we_in = we;
    #1;
    n_chk++;
    if (rf_we_out !== (we & ~(u | o))) begin
      n_bad++;
      $display("FAIL R10 (%s): rf_we_o=%0b expected %0b", tag, rf_we_out, we & ~(u | o));
    end
    e.red = 0;
    if (u | o) begin
      m_cause = u ? 0 : 1;
      m_pk = m_k; m_pie = m_ie; m_k = 1; m_ie = 0;
      m_epc = p - 4;
      m_npc = v ? (32'h80 + (32'(m_cause) << 7)) : 32'h8000_0080;
      e.red = 1;
    end else if (r) begin
      m_k = m_pk; m_ie = m_pie; m_npc = m_epc; e.red = 1;
    end
    e.tag = tag; e.npc = m_npc; e.cause = m_cause; e.epc = m_epc;
    e.k = m_k; e.ie = m_ie;
    q.push_back(e);
  endtask

  // monitor: pops one expectation per edge, a quarter period after it
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (redirect !== e.red || next_pc !== e.npc || cause !== e.cause ||
            epc !== e.epc || kernel !== e.k || ie !== e.ie) begin
          n_bad++;
          $display("FAIL %s: red=%0b npc=%h cause=%0d epc=%h k=%0b ie=%0b expected red=%0b npc=%h cause=%0d epc=%h k=%0b ie=%0b",
                   e.tag, redirect, next_pc, cause, epc, kernel, ie,
                   e.red, e.npc, e.cause, e.epc, e.k, e.ie);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    undef_req = 0; ovf_req = 0; eret = 0; vec_mode = 0; pc = '0; rf_we_in = 0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (kernel !== 1 || ie !== 0 || cause !== 0 || epc !== 0 || next_pc !== 0 || redirect !== 0) begin
      n_bad++;
      $display("FAIL R1: k=%0b ie=%0b cause=%0d epc=%h npc=%h red=%0b expected 1 0 0 0 0 0",
               kernel, ie, cause, epc, next_pc, redirect);
    end
    rst = 0;
    step("R1", 0, 0, 0, 0, 32'h0, 0);
    step("R8", 0, 0, 1, 0, 32'h0, 0);             // return after reset -> user, ie on
    step("R11", 0, 0, 0, 0, 32'h0, 1);            // R10 pass-through
    step("R2", 1, 0, 0, 0, 32'h1004, 1);          // R4 R5 R7
    step("R11", 0, 0, 0, 0, 32'h0, 0);
    step("R8", 0, 0, 1, 0, 32'h0, 0);
    step("R6", 0, 1, 0, 1, 32'h2008, 1);          // R2 cause 1, R10
    step("R8", 0, 0, 1, 0, 32'h0, 0);
    step("R3", 1, 1, 0, 1, 32'h3000, 1);          // R6 cause 0 -> 0x80
    step("R7", 0, 1, 0, 0, 32'h0000_0040, 0);     // nested: pushes kernel
    step("R8", 0, 0, 1, 0, 32'h0, 0);             // stays kernel, ie off
    step("R9", 0, 1, 1, 1, 32'h5554, 1);          // trap beats return
    step("R11", 0, 0, 0, 1, 32'h0, 0);
    step("R8", 0, 0, 1, 0, 32'h0, 0);
    step("R11", 0, 0, 0, 0, 32'h0, 0);
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule